// File: doc/BRIEF.md
# Phase-Step Crossover Timer

This block times how long a phase-locked loop takes to start overshooting after a known phase step is injected into it. Each reference cycle it receives one early/late decision from a bang-bang phase comparator. It also receives a strobe that marks the cycle in which the step was applied. The decision in the first cycle after the strobe sets the reference polarity. From then on the block counts cycles until the decision first takes the opposite polarity, which is the moment the loop starts to correct past zero phase error.

When that reversal is seen, the count is frozen and a done flag is raised. Both stay as they are until a new step strobe or a reset arrives. A short crossover count means a wide closed-loop bandwidth. If no reversal arrives, the counter saturates at its all-ones value and an overflow flag is raised together with done. The comparator and the synchronisation of its output sit outside the block, so the decision arrives as a clean one-bit input each clock.

Top module: `xover_timer`

## Requirements
- R1: Right after a synchronous reset, `cross_cnt` is 0 and `done`, `overflow` and `busy` are all 0.
- R2: While no measurement has been started, changes on `late_early` have no effect: `cross_cnt` stays 0 and `done` stays 0.
- R3: The value of `late_early` sampled in the first clock after `step_applied` becomes the reference polarity. Either value, 1 (feedback early) or 0 (feedback late), is accepted as the reference.
- R4: `cross_cnt` equals the number of consecutive samples with the reference polarity, counting from that first sample. `done` rises right after the clock edge that samples the first opposite value, and `cross_cnt` then holds one less than that sample's position, where the first sample after the step is position 1.
- R5: Once `done` is high, `cross_cnt`, `done` and `overflow` hold their values whatever `late_early` does, until a new step or a reset.
- R6: The 10-bit count never wraps. If 1024 consecutive samples all carry the reference polarity, `cross_cnt` holds 1023 and `overflow` and `done` rise together. If the 1024th sample is the opposite value, `done` rises with `cross_cnt` = 1023 and `overflow` stays 0.
- R7: A reversal that lasts only a single sample is accepted as the crossover. No filtering is applied.
- R8: A `step_applied` pulse in any state, including during a measurement or after `done`, restarts the measurement. In the next cycle `cross_cnt` is 0, `done` and `overflow` are 0, and `busy` is 1.
- R9: `busy` is high from the cycle after `step_applied` until `done` rises, and `busy` and `done` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| step_applied | input | 1 | One-cycle strobe marking the injected phase step |
| late_early | input | 1 | Bang-bang decision: 1 = feedback early, 0 = feedback late |
| cross_cnt | output | 10 | Cycles counted before the first sign reversal (saturating) |
| done | output | 1 | Measurement finished; count frozen |
| overflow | output | 1 | No reversal seen before the count saturated |
| busy | output | 1 | Measurement in progress |

## Verification
The timer is tried with sign sequences that start at either polarity and reverse after 1, 4, 36, 299 and 1023 samples of the reference polarity. These cases show that the reference is taken from the first sample and not from a fixed level, and they test the count's off-by-one at both ends. A sequence that never reverses, compared with one that reverses exactly at the 1024th sample, separates a saturation from a genuine late crossover. A single-sample glitch followed by more activity shows that the first reversal is taken and that later activity leaves the frozen result alone. Steps issued mid-run and after completion, and toggling with no step, show that the restart works and that the idle state ignores the input.

// File: rtl/xover_pkg.sv
package xover_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2,
        ST_HOLD = 2'd3
    } xover_state_t;

    typedef struct packed {
        logic fin;
        logic sat;
    } xover_flags_t;

    function automatic int unsigned sat_value(input int unsigned width);
        return (1 << width) - 1;
    endfunction

endpackage

// File: rtl/xover_sign_track.sv
module xover_sign_track (
    input  logic clk,
    input  logic rst,
    input  logic capture,
    input  logic sample,
    output logic ref_pol,
    output logic flipped
);
    logic ref_q;

    always_ff @(posedge clk) begin
        if (rst)
            ref_q <= 1'b0;
        else if (capture)
            ref_q <= sample;
    end

    assign ref_pol = ref_q;
    assign flipped = sample ^ ref_q;

    AST_REF_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        capture |=> (ref_pol == $past(sample)));  // R3

endmodule

// File: rtl/xover_sat_counter.sv
module xover_sat_counter #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load_one,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             at_max
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (load_one)
            cnt_q <= ONE;
        else if (inc && (cnt_q != MAXV))
            cnt_q <= cnt_q + ONE;
    end

    assign cnt    = cnt_q;
    assign at_max = (cnt_q == MAXV);

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (at_max && !clr && !load_one) |=> (cnt == MAXV));  // R6

endmodule

// File: rtl/xover_timer.sv
module xover_timer
    import xover_pkg::*;
#(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_applied,
    input  logic             late_early,
    output logic [CNT_W-1:0] cross_cnt,
    output logic             done,
    output logic             overflow,
    output logic             busy
);
    localparam logic [CNT_W-1:0] MAXV = CNT_W'(sat_value(CNT_W));

    xover_state_t state_q, state_d;
    xover_flags_t flags_q, flags_d;
    logic         capture, load_one, inc, flipped, ref_pol, at_max;

    xover_sign_track u_sign (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .sample  (late_early),
        .ref_pol (ref_pol),
        .flipped (flipped)
    );

    xover_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr      (step_applied),
        .load_one (load_one),
        .inc      (inc),
        .cnt      (cross_cnt),
        .at_max   (at_max)
    );

    always_comb begin
        state_d  = state_q;
        flags_d  = flags_q;
        capture  = 1'b0;
        load_one = 1'b0;
        inc      = 1'b0;
        if (step_applied) begin
            state_d = ST_ARM;
            flags_d = '0;
        end else begin
            unique case (state_q)
                ST_ARM: begin
                    capture  = 1'b1;
                    load_one = 1'b1;
                    state_d  = ST_RUN;
                end
                ST_RUN: begin
                    if (flipped) begin
                        state_d     = ST_HOLD;
                        flags_d.fin = 1'b1;
                    end else if (at_max) begin
                        state_d     = ST_HOLD;
                        flags_d.fin = 1'b1;
                        flags_d.sat = 1'b1;
                    end else begin
                        inc = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            flags_q <= '0;
        end else begin
            state_q <= state_d;
            flags_q <= flags_d;
        end
    end

    assign done     = flags_q.fin;
    assign overflow = flags_q.sat;
    assign busy     = (state_q == ST_ARM) || (state_q == ST_RUN);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !step_applied) |=> (cross_cnt == '0 && !done));  // R2
    AST_FIRST_CMP_ONE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ARM && !step_applied) |=> (cross_cnt == CNT_W'(1) && busy));  // R4
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (done && !step_applied) |=> ($stable(cross_cnt) && done && $stable(overflow)));  // R5
    AST_OVF_AT_MAX: assert property (@(posedge clk) disable iff (rst)
        overflow |-> (done && cross_cnt == MAXV));  // R6
    AST_STEP_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        step_applied |=> (cross_cnt == '0 && !done && !overflow && busy));  // R8
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));  // R9

endmodule

// File: tb/xover_timer_bench.sv
module xover_timer_bench;
    localparam int CW  = 10;
    localparam int MAX = (1 << CW) - 1;
    localparam int NV  = 7;
    // pol, flip position (1-based sample index), total samples, expected count, expected overflow
    localparam int V_POL [NV] = '{0, 1, 1, 0, 1, 0, 1};
    localparam int V_FLP [NV] = '{2, 2, 5, 37, 300, MAX + 1, 0};
    localparam int V_TOT [NV] = '{2, 2, 5, 37, 300, MAX + 1, MAX + 1};
    localparam int V_CNT [NV] = '{1, 1, 4, 36, 299, MAX, MAX};
    localparam int V_OVF [NV] = '{0, 0, 0, 0, 0, 0, 1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic step_applied = 1'b0;
    logic late_early = 1'b0;
    logic [CW-1:0] cross_cnt;
    logic done, overflow, busy;
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    xover_timer #(.CNT_W(CW)) u_xover_timer (
        .clk          (clk),
        .rst          (rst),
        .step_applied (step_applied),
        .late_early   (late_early),
        .cross_cnt    (cross_cnt),
        .done         (done),
        .overflow     (overflow),
        .busy         (busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_result(input string req, input int cnt, input int dn, input int ov);
        check(int'(cross_cnt) == cnt, {req, " count"}, int'(cross_cnt), cnt);
        check(int'(done) == dn, {req, " done"}, int'(done), dn);
        check(int'(overflow) == ov, {req, " overflow"}, int'(overflow), ov);
    endtask

    // Step, then samples 1..total; sample i = pol, inverted at i == flip
    task automatic run_seq(input int pol, input int flip, input int total);
        @(negedge clk);
        step_applied = 1'b1;
        for (int i = 1; i <= total; i++) begin
            @(negedge clk);
            step_applied = 1'b0;
            if (i == 1) begin
                check(cross_cnt == '0 && !done && !overflow && busy, "R8 restart", int'(cross_cnt), 0);
            end
            if (i == flip) begin
                check(!done && busy, "R9 busy before flip", int'(done), 0);
            end
            late_early = ((i == flip) ? 1'b1 : 1'b0) ^ pol[0];
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_result("R1 reset", 0, 0, 0);
        check(!busy, "R1 busy", int'(busy), 0);

        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            late_early = i[0];
        end
        @(negedge clk);
        check_result("R2 idle toggles", 0, 0, 0);

        for (int v = 0; v < NV; v++) begin
            run_seq(V_POL[v], V_FLP[v], V_TOT[v]);
            check_result("R4 R3 R6 vector", V_CNT[v], 1, V_OVF[v]);
            check(!busy, "R9 busy after done", int'(busy), 0);
        end

        // Single-sample glitch followed by further activity
        run_seq(1, 7, 20);
        check_result("R7 glitch accepted", 6, 1, 0);
        repeat (5) begin
            @(negedge clk);
            late_early = ~late_early;
        end
        @(negedge clk);
        check_result("R5 hold after done", 6, 1, 0);

        // Restart mid-run: second step discards the first measurement
        run_seq(0, 0, 40);
        check(busy && !done, "R8 still running", int'(busy), 1);
        run_seq(1, 10, 10);
        check_result("R8 mid-run restart", 9, 1, 0);

        // Restart after overflow clears the flags
        run_seq(0, 0, MAX + 1);
        check_result("R6 overflow again", MAX, 1, 1);
        run_seq(0, 3, 3);
        check_result("R8 restart after overflow", 2, 1, 0);

        // Reset mid-run
        run_seq(1, 0, 15);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_result("R1 reset mid-run", 0, 0, 0);
        check(!busy, "R1 busy after reset", int'(busy), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule